// File: doc/BRIEF.md
# Programmable Timer Counter Channel with Match Compare

This block is one timer channel with a 16-bit count. It advances on a tick. The tick comes from the system clock, or from a synchronised edge of an external clock input, and can be divided down by a power-of-two prescaler. The count runs up or down. In free-running mode it wraps across its whole range and flags an overflow. In interval mode it wraps at a programmed limit and flags an interval event. Three match registers are compared with the count, and a match flags an event only when match mode is enabled.

Six event sources collect in a sticky status register. Software clears a bit by writing 1 to it. An enable mask selects which status bits drive the single interrupt line. A waveform output goes active when the count reaches the first match value and returns inactive when the count wraps. The output can be inverted or forced inactive.

Software reaches the channel through a small register bus. A write takes effect at the clock edge where it is sampled. A read returns data one cycle after it is issued, with a valid strobe.

Top module: `tmr_channel`

## Requirements
- R1: After reset, control (address 0) reads 0x0021 (halt bit 0 set, waveform-off bit 5 set), clock setup (address 1) reads 0 (internal clock, no prescale), the count (address 2), the enable mask (address 7) and the status (address 8) read 0, and `wave_out` and `irq` are low.
- R2: With halt clear and the internal clock unscaled, the count changes once per cycle. Setting halt freezes it. Clearing halt again resumes from the held value.
- R3: Clock setup bit 0 enables the prescaler and bits 4:1 hold N. Only every 2^(N+1)-th source event then advances the count.
- R4: Clock setup bit 5 selects the external clock input. Bit 6 chooses its falling edge instead of its rising edge. Each qualifying edge seen while running advances the count once.
- R5: Writing control bit 4 requests a restart. The request self-clears after one cycle. The count then reloads with 0 when counting up, 0xFFFF when counting down in free mode, or the interval value (address 3) when counting down in interval mode. The halt bit is unchanged.
- R6: Control bit 2 makes the count decrement.
- R7: In free mode (control bit 1 clear), the count wraps from 0xFFFF to 0 going up, or from 0 to 0xFFFF going down, and sets status bit 4 (overflow) but not status bit 0.
- R8: In interval mode (control bit 1 set), an up count wraps to 0 on the tick after it reaches the interval value, and a down count at 0 reloads the interval value. Either wrap sets status bit 0 and never status bit 4.
- R9: With control bit 3 set, the count arriving at match register i (addresses 4, 5, 6) sets status bit 1+i. With control bit 3 clear, no match bit is set.
- R10: Status bits are sticky. Writing 1 to a status bit clears it and writing 0 leaves it. `irq` is high while any status bit is set whose enable bit is set. A pulse on `evt_in` sets status bit 5.
- R11: The waveform level goes active when the count arrives at match register 0. It goes inactive on any wrap or restart. Control bit 6 inverts `wave_out`. Control bit 5 forces `wave_out` to its inactive level, which is low, or high when inverted.
- R12: A read with `bus_rd` returns the addressed register on `bus_rdata` with `bus_rvalid` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External count clock, sampled by `clk` |
| evt_in | input | 1 | One-cycle pulse from event-timer logic |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| irq | output | 1 | Interrupt, OR of enabled status bits |
| wave_out | output | 1 | Waveform output |

## Verification
An off-by-one in the wrap compare, or a wrong reload value, shows up as a wrong count on the first read after the affected tick. It also shows up as a wrong or extra status bit, read back the same cycle. Prescaler or edge-detect faults change the number of ticks in a known run window, so the count read after halting differs by at least one. Faults in the sticky status or in the enable gating appear on `irq` right after the write that should set or clear them. A waveform fault appears on `wave_out` as soon as the count passes match register 0 or wraps.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef struct packed {
      logic wave_inv;   // bit 6
      logic wave_off;   // bit 5
      logic restart;    // bit 4, self-clearing
      logic match_en;   // bit 3
      logic count_dn;   // bit 2
      logic ivl_mode;   // bit 1
      logic halt;       // bit 0
   } tmr_ctrl_t;

   localparam int CTRL_W = $bits(tmr_ctrl_t);
   localparam tmr_ctrl_t CTRL_RST = '{wave_inv: 1'b0, wave_off: 1'b1, restart: 1'b0,
                                     match_en: 1'b0, count_dn: 1'b0, ivl_mode: 1'b0,
                                     halt: 1'b1};

   localparam int A_CTRL   = 0;
   localparam int A_CLKCFG = 1;
   localparam int A_COUNT  = 2;
   localparam int A_IVL    = 3;
   localparam int A_MATCH0 = 4;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int PS_W        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ext_clk,
   input  logic            ext_sel,
   input  logic            ext_fall,
   input  logic            ps_en,
   input  logic [PS_W-1:0] ps_div,
   input  logic            run,
   input  logic            clr,
   output logic            tick
);
   localparam int DIV_W = 1 << PS_W;
   localparam logic [DIV_W-1:0] ONES = '1;

   initial begin
      if (SYNC_STAGES < 2) $fatal(1, "tmr_tick_gen: SYNC_STAGES must be at least 2");
      if (PS_W < 1 || PS_W > 5) $fatal(1, "tmr_tick_gen: PS_W out of range");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   src_q;
   logic                   src_lvl;
   logic                   src_evt;
   logic [DIV_W-1:0]       div_q;
   logic [DIV_W-1:0]       div_mask;
   logic [PS_W-1:0]        shamt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= ext_clk;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b0;
         else        sync_q[s] <= sync_q[s-1];
      end
   end

   assign src_lvl = sync_q[SYNC_STAGES-1] ^ ext_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= 1'b0;
      else        src_q <= src_lvl;
   end

   assign src_evt  = ext_sel ? (src_lvl & ~src_q) : 1'b1;
   assign shamt    = PS_W'(DIV_W - 1) - ps_div;
   assign div_mask = ONES >> shamt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        div_q <= '0;
      else if (clr)                      div_q <= '0;
      else if (run && src_evt && ps_en)  div_q <= div_q + 1'b1;
   end

   assign tick = run && src_evt && (!ps_en || ((div_q & div_mask) == div_mask));

   // a divided tick is never followed by another one in the next cycle
   p_div_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_en && tick) |=> (!tick || !ps_en));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic             count_dn,
   input  logic             ivl_mode,
   input  logic [CNT_W-1:0] ivl_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             adv,
   output logic             ivl_evt,
   output logic             ovf_evt
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic [CNT_W-1:0] reload;

   always_comb begin
      if (!count_dn)     reload = '0;
      else if (ivl_mode) reload = ivl_val;
      else               reload = CMAX;
   end

   assign adv = tick && !restart;

   always_comb begin
      cnt_nxt = cnt_q;
      ivl_evt = 1'b0;
      ovf_evt = 1'b0;
      if (restart) begin
         cnt_nxt = reload;
      end else if (tick) begin
         if (!count_dn) begin
            if (ivl_mode && cnt_q >= ivl_val) begin
               cnt_nxt = '0;
               ivl_evt = 1'b1;
            end else if (!ivl_mode && cnt_q == CMAX) begin
               cnt_nxt = '0;
               ovf_evt = 1'b1;
            end else begin
               cnt_nxt = cnt_q + 1'b1;
            end
         end else begin
            if (cnt_q == '0) begin
               cnt_nxt = ivl_mode ? ivl_val : CMAX;
               ivl_evt = ivl_mode;
               ovf_evt = !ivl_mode;
            end else begin
               cnt_nxt = cnt_q - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> (cnt_q == $past(cnt_q)));

   p_reload_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !count_dn) |=> (cnt_q == '0));

   p_ivl_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ivl_mode && !count_dn && cnt_q < ivl_val) |=> (cnt_q <= $past(ivl_val)));

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
   parameter int IRQ_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] set,
   input  logic             clr_we,
   input  logic [IRQ_W-1:0] clr_mask,
   input  logic [IRQ_W-1:0] en,
   output logic [IRQ_W-1:0] stat_q,
   output logic             irq
);
   logic [IRQ_W-1:0] clr_eff;

   assign clr_eff = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_eff) | set;
   end

   assign irq = |(stat_q & en);

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_q & ~clr_eff)) |=> ((stat_q & $past(stat_q & ~clr_eff)) == $past(stat_q & ~clr_eff)));

   p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && ((set & clr_mask) == '0)) |=> ((stat_q & $past(clr_mask)) == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PS_W        = 4,
   parameter int N_MATCH     = 3,
   parameter int SYNC_STAGES = 2,
   parameter int AW          = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_clk,
   input  logic             evt_in,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [AW-1:0]    bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic             bus_rvalid,
   output logic             irq,
   output logic             wave_out
);
   localparam int IRQ_W  = N_MATCH + 3;
   localparam int CLK_W  = PS_W + 3;
   localparam int A_EN   = A_MATCH0 + N_MATCH;
   localparam int A_STAT = A_EN + 1;

   initial begin
      if (CNT_W < CTRL_W || CNT_W < CLK_W || CNT_W < IRQ_W)
         $fatal(1, "tmr_channel: CNT_W too narrow for register fields");
      if (N_MATCH < 1 || A_STAT >= (1 << AW))
         $fatal(1, "tmr_channel: N_MATCH does not fit the address space");
   end

   tmr_ctrl_t        ctrl_q;
   logic [CLK_W-1:0] clk_q;
   logic [CNT_W-1:0] ivl_q;
   logic [CNT_W-1:0] match_q [N_MATCH];
   logic [IRQ_W-1:0] en_q;
   logic [IRQ_W-1:0] stat_q;
   logic [N_MATCH-1:0] hit;
   logic [IRQ_W-1:0] set_vec;
   logic [CNT_W-1:0] cnt_q, cnt_nxt, rd_mux;
   logic             tick, adv, ivl_evt, ovf_evt, wave_lvl, wr_ctrl;

   assign wr_ctrl = bus_wr && (bus_addr == AW'(A_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         clk_q  <= '0;
         ivl_q  <= '0;
         en_q   <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
         else         ctrl_q.restart <= 1'b0;
         if (bus_wr && bus_addr == AW'(A_CLKCFG)) clk_q <= bus_wdata[CLK_W-1:0];
         if (bus_wr && bus_addr == AW'(A_IVL))    ivl_q <= bus_wdata;
         if (bus_wr && bus_addr == AW'(A_EN))     en_q  <= bus_wdata[IRQ_W-1:0];
      end
   end

   for (genvar i = 0; i < N_MATCH; i++) begin : g_match
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     match_q[i] <= '0;
         else if (bus_wr && bus_addr == AW'(A_MATCH0 + i)) match_q[i] <= bus_wdata;
      end
      assign hit[i] = adv && (cnt_nxt == match_q[i]);
   end

   tmr_tick_gen #(.PS_W(PS_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_clk  (ext_clk),
      .ext_sel  (clk_q[PS_W+1]),
      .ext_fall (clk_q[PS_W+2]),
      .ps_en    (clk_q[0]),
      .ps_div   (clk_q[PS_W:1]),
      .run      (!ctrl_q.halt),
      .clr      (ctrl_q.restart),
      .tick     (tick)
   );

   tmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .restart  (ctrl_q.restart),
      .count_dn (ctrl_q.count_dn),
      .ivl_mode (ctrl_q.ivl_mode),
      .ivl_val  (ivl_q),
      .cnt_q    (cnt_q),
      .cnt_nxt  (cnt_nxt),
      .adv      (adv),
      .ivl_evt  (ivl_evt),
      .ovf_evt  (ovf_evt)
   );

   assign set_vec = {evt_in, ovf_evt, hit & {N_MATCH{ctrl_q.match_en}}, ivl_evt};

   tmr_irq_ctrl #(.IRQ_W(IRQ_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (set_vec),
      .clr_we   (bus_wr && bus_addr == AW'(A_STAT)),
      .clr_mask (bus_wdata[IRQ_W-1:0]),
      .en       (en_q),
      .stat_q   (stat_q),
      .irq      (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  wave_lvl <= 1'b0;
      else if (ctrl_q.restart)     wave_lvl <= 1'b0;
      else if (hit[0])             wave_lvl <= 1'b1;
      else if (ivl_evt || ovf_evt) wave_lvl <= 1'b0;
   end

   assign wave_out = ctrl_q.wave_off ? ctrl_q.wave_inv : (wave_lvl ^ ctrl_q.wave_inv);

   always_comb begin
      rd_mux = '0;
      if (bus_addr == AW'(A_CTRL))   rd_mux[CTRL_W-1:0] = ctrl_q;
      if (bus_addr == AW'(A_CLKCFG)) rd_mux[CLK_W-1:0]  = clk_q;
      if (bus_addr == AW'(A_COUNT))  rd_mux = cnt_q;
      if (bus_addr == AW'(A_IVL))    rd_mux = ivl_q;
      for (int i = 0; i < N_MATCH; i++)
         if (bus_addr == AW'(A_MATCH0 + i)) rd_mux = match_q[i];
      if (bus_addr == AW'(A_EN))     rd_mux[IRQ_W-1:0] = en_q;
      if (bus_addr == AW'(A_STAT))   rd_mux[IRQ_W-1:0] = stat_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_rd;
         if (bus_rd) bus_rdata <= rd_mux;
      end
   end

   // the restart request only survives one cycle unless rewritten
   p_restart_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.restart |=> (!ctrl_q.restart || $past(wr_ctrl)));

   p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid);

endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_clk = 1'b0;
   logic        evt_in = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_rvalid;
   logic        irq;
   logic        wave_out;

   int vec_n = 0;
   int miss_n = 0;
   bit done = 1'b0;

   logic [15:0] exp_q [$];
   string       tag_q [$];

   always #2 clk = ~clk;

   tmr_channel dut (
      .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .evt_in(evt_in),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq), .wave_out(wave_out)
   );

   localparam logic [3:0] CTRL = 0, CLKC = 1, CNT = 2, IVL = 3, M0 = 4, M1 = 5, M2 = 6,
                          EN = 7, STAT = 8;

   // monitor: pops the expected read data as the design returns it
   always @(negedge clk) begin
      if (bus_rvalid) begin
         logic [15:0] e;
         string t;
         if (exp_q.size() == 0) begin
            miss_n++;
            $display("FAIL R12 unexpected read data actual=%h expected=none", bus_rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vec_n++;
            if (bus_rdata !== e) begin
               miss_n++;
               $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic chk(input logic [3:0] a, input logic [15:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic pin(input logic act, input logic e, input string t);
      vec_n++;
      if (act !== e) begin
         miss_n++;
         $display("FAIL %s actual=%b expected=%b", t, act, e);
      end
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic ext_to(input logic v);
      @(negedge clk);
      ext_clk = v;
      idle(4);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miss_n++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      chk(CTRL, 16'h0021, "R1 ctrl reset");
      chk(CLKC, 16'h0000, "R1 clock setup reset");
      chk(CNT,  16'h0000, "R1 count reset");
      chk(EN,   16'h0000, "R1 enable reset");
      chk(STAT, 16'h0000, "R1 status reset");
      pin(wave_out, 1'b0, "R1 wave reset");
      pin(irq, 1'b0, "R1 irq reset");

      // R2 up count, hold, resume
      wr(CTRL, 16'h0000); idle(8); wr(CTRL, 16'h0001);
      chk(CNT, 16'd10, "R2 up count");
      idle(5);
      chk(CNT, 16'd10, "R2 hold while halted");
      wr(CTRL, 16'h0000); idle(3); wr(CTRL, 16'h0001);
      chk(CNT, 16'd15, "R2 resume from held value");

      // R5 restart reloads, keeps halt, self-clears
      wr(CTRL, 16'h0011); idle(2);
      chk(CTRL, 16'h0001, "R5 restart self-clears, halt kept");
      chk(CNT, 16'h0000, "R5 up reload");
      wr(CTRL, 16'h0015); idle(2);
      chk(CNT, 16'hFFFF, "R5 down free reload");
      // R6 down counting
      wr(CTRL, 16'h0004); idle(2); wr(CTRL, 16'h0005);
      chk(CNT, 16'hFFFB, "R6 down count");
      wr(IVL, 16'd100); wr(CTRL, 16'h0017); idle(2);
      chk(CNT, 16'd100, "R5 down interval reload");

      // R7 free-mode wrap downward
      wr(CTRL, 16'h0011); wr(STAT, 16'h003F);
      wr(CTRL, 16'h0004); wr(CTRL, 16'h0005);
      chk(CNT, 16'hFFFE, "R7 down wrap count");
      chk(STAT, 16'h0010, "R7 overflow bit only");

      // R8 interval down wrap; R9 match gated off (match0 = 0 reached)
      wr(IVL, 16'd3); wr(CTRL, 16'h0017); wr(STAT, 16'h003F);
      wr(CTRL, 16'h0006); idle(3); wr(CTRL, 16'h0007);
      chk(CNT, 16'd2, "R8 down interval wrap count");
      chk(STAT, 16'h0001, "R8 interval bit only, R9 no match when disabled");

      // R8 interval up wrap
      wr(IVL, 16'd5); wr(CTRL, 16'h0013); wr(STAT, 16'h003F);
      wr(CTRL, 16'h0002); idle(5); wr(CTRL, 16'h0003);
      chk(CNT, 16'd1, "R8 up interval wrap count");
      chk(STAT, 16'h0001, "R8 up interval bit only");

      // R9 match, R11 waveform
      wr(M0, 16'd3); wr(M1, 16'd7); wr(M2, 16'd200);
      wr(CTRL, 16'h0019); wr(STAT, 16'h003F);
      pin(wave_out, 1'b0, "R11 wave low after restart");
      wr(CTRL, 16'h0008); idle(8); wr(CTRL, 16'h0009);
      chk(CNT, 16'd10, "R9 count during match run");
      chk(STAT, 16'h0006, "R9 match0 and match1 set, match2 not");
      pin(wave_out, 1'b1, "R11 wave active after match0");
      wr(CTRL, 16'h0049);
      pin(wave_out, 1'b0, "R11 wave inverted");
      wr(CTRL, 16'h0069);
      pin(wave_out, 1'b1, "R11 wave forced inactive inverted");
      wr(CTRL, 16'h0029);
      pin(wave_out, 1'b0, "R11 wave forced inactive");

      // R10 enable gating and write-one-to-clear
      pin(irq, 1'b0, "R10 irq masked");
      wr(EN, 16'h0004);
      pin(irq, 1'b1, "R10 irq enabled");
      wr(STAT, 16'h0002);
      chk(STAT, 16'h0004, "R10 selective clear");
      pin(irq, 1'b1, "R10 irq holds");
      wr(STAT, 16'h0004);
      chk(STAT, 16'h0000, "R10 cleared");
      pin(irq, 1'b0, "R10 irq drops");
      @(negedge clk); evt_in = 1'b1; @(negedge clk); evt_in = 1'b0;
      chk(STAT, 16'h0020, "R10 event input bit");
      wr(EN, 16'h0020);
      pin(irq, 1'b1, "R10 irq from event");
      wr(STAT, 16'h003F); wr(EN, 16'h0000);

      // R11 wrap clears waveform level
      wr(IVL, 16'd12); wr(CTRL, 16'h000A); idle(1); wr(CTRL, 16'h000B);
      chk(CNT, 16'd0, "R8 interval wrap at 12");
      chk(STAT, 16'h0001, "R8 wrap status");
      pin(wave_out, 1'b0, "R11 wave low after wrap");
      wr(STAT, 16'h003F);

      // R3 prescaler
      wr(CLKC, 16'h0001); wr(CTRL, 16'h0011);
      wr(CTRL, 16'h0000); idle(6); wr(CTRL, 16'h0001);
      chk(CNT, 16'd4, "R3 divide by 2");
      wr(CLKC, 16'h0003); wr(CTRL, 16'h0011);
      wr(CTRL, 16'h0000); idle(10); wr(CTRL, 16'h0001);
      chk(CNT, 16'd3, "R3 divide by 4");

      // R4 external clock, rising then falling edges
      wr(CLKC, 16'h0020); wr(CTRL, 16'h0011); wr(CTRL, 16'h0000);
      idle(6);
      ext_to(1'b1); ext_to(1'b0); ext_to(1'b1); ext_to(1'b0); ext_to(1'b1);
      idle(6); wr(CTRL, 16'h0001);
      chk(CNT, 16'd3, "R4 rising edges counted");
      wr(CLKC, 16'h0060); wr(CTRL, 16'h0011); wr(CTRL, 16'h0000);
      idle(6);
      ext_to(1'b0); ext_to(1'b1); ext_to(1'b0); ext_to(1'b1);
      idle(6); wr(CTRL, 16'h0001);
      chk(CNT, 16'd2, "R4 falling edges counted");

      idle(4);
      finish_run();
   end

endmodule